// File: doc/BRIEF.md
# Circular Descriptor List Engine

This block sits on the device side of a host link and moves work through two rings held in host memory. The host programs a 64-bit base for the request ring, a 64-bit base for the completion ring and a 64-bit address for a shadow word. It posts work by filling request units and then advancing a write index. The engine sees that the write index has moved ahead of its own consumed index. It fetches the next 16-byte unit through a read port and hands the unit's buffer address and length to a consumer over a valid/ready handshake, one unit per cycle.

When the device finishes a request it offers a 32-bit flag word. The engine ORs a fixed host-bits mask into the flag and writes it into the next 4-byte unit of the completion ring. In the following cycle it writes the new producer index to the shadow address. The host compares that index with its own saved read index to find new work. The host reports its read index back so that no unconsumed completion unit is ever overwritten. A command/response register pair carries commands that bypass the rings. Two cause bits, gated by enables, drive one interrupt line.

Top module: `cdl_engine`

## Requirements
- R1: After reset the ring holds 8 units, every index (host write index, consumed index, producer index, host read index) reads 7, `req_valid` and `irq` are 0 and `cpl_ready` is 1.
- R2: While the consumed index differs from the host write index, `req_valid` is 1 and `inb_rd_addr` equals the request base plus 16 times the next index. `req_addr` is bits 63:0 of `inb_rd_data` with bits 4:0 forced to zero (32-byte alignment), and `req_size` is bits 95:64. Each cycle with `req_valid` and `req_ready` both high consumes exactly one unit.
- R3: The index after N-1 is 0. A value written to the host write index (0x4018) or the host read index (0x4060) is reduced modulo N.
- R4: An accepted completion writes `cpl_flag | 0x8000_0000` to the completion base plus 4 times the next producer index. In the next cycle it writes the new producer index, zero-extended, to the shadow address, with `cpl_ready` low. Register 0x4064 reads that index.
- R5: When the next producer index equals the host read index, `cpl_ready` is 0 and no host write occurs until the host read index moves.
- R6: Writing the configuration register (0x402C) sets log2(N) from bits 3:0, clamped to the range 1..8, and puts every index at the new N-1 in the same cycle.
- R7: Cause bit 0 is set by each posted completion and cause bit 1 by each device response write. Writing 1 to a bit of 0x4088 clears it. `irq` is the OR over bits of (cause AND enable), with the enable at 0x408C.
- R8: A host write to 0x4100 shows the value on `msg_cmd` with a one-cycle `msg_cmd_new` pulse. `msg_rsp_wr` loads `msg_rsp_data` into 0x4104. Bit 0 of 0x4108 reads 1 when the response equals the command.
- R9: The base registers read back what was written: request base at 0x4000/0x4004, completion base at 0x4050/0x4054, shadow address at 0x4058/0x405C (low word first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| inb_rd_addr | output | 64 | Host address of the request unit to fetch |
| inb_rd_data | input | 96 | Fetched unit: length in 95:64, buffer address in 63:0 |
| req_valid | output | 1 | A request unit is presented |
| req_ready | input | 1 | Consumer takes the unit |
| req_addr | output | 64 | Aligned buffer address of the unit |
| req_size | output | 32 | Buffer length of the unit |
| cpl_valid | input | 1 | Device offers a completion |
| cpl_ready | output | 1 | Completion accepted this cycle |
| cpl_flag | input | 32 | Completion flag word |
| hwr_en | output | 1 | Host memory write strobe |
| hwr_addr | output | 64 | Host memory write address |
| hwr_data | output | 32 | Host memory write data |
| msg_cmd | output | 32 | Last command written by the host |
| msg_cmd_new | output | 1 | One-cycle pulse after a command write |
| msg_rsp_wr | input | 1 | Device writes a response |
| msg_rsp_data | input | 32 | Response value |
| irq | output | 1 | Interrupt request |

## Verification
A consumed index that lags or skips shows up on the next cycle as a wrong `inb_rd_addr` or a wrongly asserted `req_valid`. A bad producer index shows up as a completion written to the wrong unit on the very next accept, and as a wrong shadow value one cycle after that. A lost full condition appears only when the ring has filled to N-1 units, so the bench drives the ring exactly to that point and holds a completion against it. A stale index after a size change is visible at once through the index registers and through `req_valid`.

// File: rtl/cdl_pkg.sv
`timescale 1ns/1ps
package cdl_pkg;
  // register byte offsets decoded by the host driver
  localparam logic [15:0] A_IN_LO    = 16'h4000;
  localparam logic [15:0] A_IN_HI    = 16'h4004;
  localparam logic [15:0] A_WPTR     = 16'h4018;
  localparam logic [15:0] A_CFG      = 16'h402C;
  localparam logic [15:0] A_OUT_LO   = 16'h4050;
  localparam logic [15:0] A_OUT_HI   = 16'h4054;
  localparam logic [15:0] A_SHD_LO   = 16'h4058;
  localparam logic [15:0] A_SHD_HI   = 16'h405C;
  localparam logic [15:0] A_HRIDX    = 16'h4060;
  localparam logic [15:0] A_SHADOW   = 16'h4064;
  localparam logic [15:0] A_CAUSE    = 16'h4088;
  localparam logic [15:0] A_ENABLE   = 16'h408C;
  localparam logic [15:0] A_MSG_CMD  = 16'h4100;
  localparam logic [15:0] A_MSG_RSP  = 16'h4104;
  localparam logic [15:0] A_MSG_DONE = 16'h4108;

  localparam int CAUSE_W = 2;
  localparam int CZ_CPL  = 0;
  localparam int CZ_MSG  = 1;

  function automatic logic [3:0] clamp_log2(input logic [3:0] raw, input int max_lg);
    if (raw == 4'd0) return 4'd1;
    if (int'(raw) > max_lg) return 4'(max_lg);
    return raw;
  endfunction

  function automatic logic [15:0] mask_of(input logic [3:0] lg);
    return (16'd1 << lg) - 16'd1;
  endfunction

  function automatic logic [15:0] ring_next(input logic [15:0] idx, input logic [15:0] mask);
    return (idx + 16'd1) & mask;
  endfunction

  function automatic logic [63:0] unit_addr(input logic [63:0] base, input logic [15:0] idx,
                                            input int lg_bytes);
    return base + (64'(idx) << lg_bytes);
  endfunction
endpackage

// File: rtl/cdl_regs.sv
`timescale 1ns/1ps
module cdl_regs import cdl_pkg::*; #(
  parameter int MAX_LOG2 = 8,
  parameter int DEF_LOG2 = 3,
  localparam int IW = MAX_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [IW-1:0]      shadow_idx,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               msg_rsp_wr,
  input  logic [31:0]        msg_rsp_data,
  output logic [63:0]        in_base,
  output logic [63:0]        out_base,
  output logic [63:0]        shd_base,
  output logic [IW-1:0]      wr_ptr,
  output logic [IW-1:0]      host_ridx,
  output logic [IW-1:0]      idx_mask,
  output logic [IW-1:0]      load_mask,
  output logic               ring_rst,
  output logic [CAUSE_W-1:0] cause_clr,
  output logic [CAUSE_W-1:0] irq_en,
  output logic [31:0]        msg_cmd,
  output logic               msg_cmd_new
);
  localparam logic [IW-1:0] RST_IDX = IW'(mask_of(4'(DEF_LOG2)));

  logic [3:0]  lg_q;
  logic [3:0]  lg_new;
  logic [31:0] msg_rsp;

  assign lg_new    = clamp_log2(reg_wdata[3:0], MAX_LOG2);
  assign idx_mask  = IW'(mask_of(lg_q));
  assign load_mask = IW'(mask_of(lg_new));
  assign ring_rst  = reg_wr && (reg_addr == A_CFG);
  assign cause_clr = (reg_wr && (reg_addr == A_CAUSE)) ? reg_wdata[CAUSE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_q <= 4'(DEF_LOG2);
      in_base <= '0; out_base <= '0; shd_base <= '0;
      wr_ptr <= RST_IDX; host_ridx <= RST_IDX;
      irq_en <= '0; msg_cmd <= '0; msg_cmd_new <= 1'b0; msg_rsp <= '0;
    end else begin
      msg_cmd_new <= reg_wr && (reg_addr == A_MSG_CMD);
      if (msg_rsp_wr) msg_rsp <= msg_rsp_data;
      if (reg_wr) begin
        case (reg_addr)
          A_IN_LO:   in_base[31:0]   <= reg_wdata;
          A_IN_HI:   in_base[63:32]  <= reg_wdata;
          A_OUT_LO:  out_base[31:0]  <= reg_wdata;
          A_OUT_HI:  out_base[63:32] <= reg_wdata;
          A_SHD_LO:  shd_base[31:0]  <= reg_wdata;
          A_SHD_HI:  shd_base[63:32] <= reg_wdata;
          A_WPTR:    wr_ptr    <= reg_wdata[IW-1:0] & idx_mask;
          A_HRIDX:   host_ridx <= reg_wdata[IW-1:0] & idx_mask;
          A_CFG: begin
            lg_q      <= lg_new;
            wr_ptr    <= load_mask;
            host_ridx <= load_mask;
          end
          A_ENABLE:  irq_en  <= reg_wdata[CAUSE_W-1:0];
          A_MSG_CMD: msg_cmd <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_IN_LO:    reg_rdata = in_base[31:0];
      A_IN_HI:    reg_rdata = in_base[63:32];
      A_OUT_LO:   reg_rdata = out_base[31:0];
      A_OUT_HI:   reg_rdata = out_base[63:32];
      A_SHD_LO:   reg_rdata = shd_base[31:0];
      A_SHD_HI:   reg_rdata = shd_base[63:32];
      A_WPTR:     reg_rdata = 32'(wr_ptr);
      A_CFG:      reg_rdata = 32'(lg_q);
      A_HRIDX:    reg_rdata = 32'(host_ridx);
      A_SHADOW:   reg_rdata = 32'(shadow_idx);
      A_CAUSE:    reg_rdata = 32'(cause);
      A_ENABLE:   reg_rdata = 32'(irq_en);
      A_MSG_CMD:  reg_rdata = msg_cmd;
      A_MSG_RSP:  reg_rdata = msg_rsp;
      A_MSG_DONE: reg_rdata = 32'(msg_rsp == msg_cmd);
      default:    reg_rdata = '0;
    endcase
  end

  // ring size field never leaves 1..MAX_LOG2
  assert_cfg_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lg_q != 4'd0) && (int'(lg_q) <= MAX_LOG2));

  // device response lands in the response register
  assert_msg_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_rsp_wr |=> (msg_rsp == $past(msg_rsp_data)));
endmodule

// File: rtl/cdl_inbound.sv
`timescale 1ns/1ps
module cdl_inbound import cdl_pkg::*; #(
  parameter int MAX_LOG2 = 8,
  parameter int DEF_LOG2 = 3,
  parameter int IN_LG    = 4,
  localparam int IW = MAX_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_rst,
  input  logic [IW-1:0] load_mask,
  input  logic [IW-1:0] idx_mask,
  input  logic [IW-1:0] wr_ptr,
  input  logic [63:0]   in_base,
  output logic [63:0]   mem_addr,
  input  logic [95:0]   mem_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [63:0]   req_addr,
  output logic [31:0]   req_size
);
  localparam logic [IW-1:0] RST_IDX = IW'(mask_of(4'(DEF_LOG2)));

  logic [IW-1:0] done_q;
  logic [IW-1:0] nxt;
  logic          taken;

  assign nxt       = IW'(ring_next(16'(done_q), 16'(idx_mask)));
  assign req_valid = (done_q != wr_ptr);
  assign mem_addr  = unit_addr(in_base, 16'(nxt), IN_LG);
  assign req_addr  = mem_data[63:0] & ~64'h1F;
  assign req_size  = mem_data[95:64];
  assign taken     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= RST_IDX;
    else if (ring_rst) done_q <= load_mask;
    else if (taken)    done_q <= nxt;
  end

  // consumed index stays inside the configured ring
  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & ~idx_mask) == '0);
endmodule

// File: rtl/cdl_outbound.sv
`timescale 1ns/1ps
module cdl_outbound import cdl_pkg::*; #(
  parameter int          MAX_LOG2  = 8,
  parameter int          DEF_LOG2  = 3,
  parameter int          OUT_LG    = 2,
  parameter logic [31:0] HOST_BITS = 32'h8000_0000,
  localparam int IW = MAX_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_rst,
  input  logic [IW-1:0] load_mask,
  input  logic [IW-1:0] idx_mask,
  input  logic [IW-1:0] host_ridx,
  input  logic [63:0]   out_base,
  input  logic [63:0]   shd_base,
  input  logic          cpl_valid,
  input  logic [31:0]   cpl_flag,
  output logic          cpl_ready,
  output logic          posted,
  output logic [IW-1:0] prod_idx,
  output logic          hwr_en,
  output logic [63:0]   hwr_addr,
  output logic [31:0]   hwr_data
);
  localparam logic [IW-1:0] RST_IDX = IW'(mask_of(4'(DEF_LOG2)));

  logic [IW-1:0] prod_q;
  logic [IW-1:0] nxt;
  logic          shd_pend_q;
  logic          full;

  assign nxt       = IW'(ring_next(16'(prod_q), 16'(idx_mask)));
  assign full      = (nxt == host_ridx);
  assign cpl_ready = !full && !shd_pend_q;
  assign posted    = cpl_valid && cpl_ready;
  assign prod_idx  = prod_q;
  assign hwr_en    = posted || shd_pend_q;
  assign hwr_addr  = shd_pend_q ? shd_base : unit_addr(out_base, 16'(nxt), OUT_LG);
  assign hwr_data  = shd_pend_q ? 32'(prod_q) : (cpl_flag | HOST_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= RST_IDX; shd_pend_q <= 1'b0;
    end else if (ring_rst) begin
      prod_q <= load_mask; shd_pend_q <= 1'b0;
    end else begin
      if (posted) prod_q <= nxt;
      shd_pend_q <= posted;
    end
  end

  // each posted unit is followed by the shadow write
  assert_shadow_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && !ring_rst) |=> (hwr_en && !cpl_ready && (hwr_addr == shd_base)));

  // a unit write never targets the unit the host reported as its read index
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr_en && !shd_pend_q) |-> (hwr_addr != unit_addr(out_base, 16'(host_ridx), OUT_LG)));
endmodule

// File: rtl/cdl_irq.sv
`timescale 1ns/1ps
module cdl_irq import cdl_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] cause_set,
  input  logic [CAUSE_W-1:0] cause_clr,
  input  logic [CAUSE_W-1:0] irq_en,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (cause & ~cause_clr) | cause_set;
  end

  assign irq = |(cause & irq_en);

  // an event always leaves its cause bit set
  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_set[CZ_CPL] |=> cause[CZ_CPL]);
endmodule

// File: rtl/cdl_engine.sv
`timescale 1ns/1ps
module cdl_engine import cdl_pkg::*; #(
  parameter int          MAX_LOG2  = 8,
  parameter int          DEF_LOG2  = 3,
  parameter int          IN_LG     = 4,
  parameter int          OUT_LG    = 2,
  parameter logic [31:0] HOST_BITS = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] inb_rd_addr,
  input  logic [95:0] inb_rd_data,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [63:0] req_addr,
  output logic [31:0] req_size,
  input  logic        cpl_valid,
  output logic        cpl_ready,
  input  logic [31:0] cpl_flag,
  output logic        hwr_en,
  output logic [63:0] hwr_addr,
  output logic [31:0] hwr_data,
  output logic [31:0] msg_cmd,
  output logic        msg_cmd_new,
  input  logic        msg_rsp_wr,
  input  logic [31:0] msg_rsp_data,
  output logic        irq
);
  localparam int IW = MAX_LOG2;

  logic [63:0]        in_base, out_base, shd_base;
  logic [IW-1:0]      wr_ptr, host_ridx, idx_mask, load_mask, prod_idx;
  logic               ring_rst, posted;
  logic [CAUSE_W-1:0] cause, cause_clr, cause_set, irq_en;

  assign cause_set = {msg_rsp_wr, posted};

  cdl_regs #(.MAX_LOG2(MAX_LOG2), .DEF_LOG2(DEF_LOG2)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .shadow_idx(prod_idx), .cause, .msg_rsp_wr, .msg_rsp_data,
    .in_base, .out_base, .shd_base, .wr_ptr, .host_ridx, .idx_mask, .load_mask,
    .ring_rst, .cause_clr, .irq_en, .msg_cmd, .msg_cmd_new);

  cdl_inbound #(.MAX_LOG2(MAX_LOG2), .DEF_LOG2(DEF_LOG2), .IN_LG(IN_LG)) u_inb (
    .clk, .rst_n, .ring_rst, .load_mask, .idx_mask, .wr_ptr, .in_base,
    .mem_addr(inb_rd_addr), .mem_data(inb_rd_data),
    .req_valid, .req_ready, .req_addr, .req_size);

  cdl_outbound #(.MAX_LOG2(MAX_LOG2), .DEF_LOG2(DEF_LOG2), .OUT_LG(OUT_LG),
                 .HOST_BITS(HOST_BITS)) u_outb (
    .clk, .rst_n, .ring_rst, .load_mask, .idx_mask, .host_ridx, .out_base, .shd_base,
    .cpl_valid, .cpl_flag, .cpl_ready, .posted, .prod_idx, .hwr_en, .hwr_addr, .hwr_data);

  cdl_irq u_irq (
    .clk, .rst_n, .cause_set, .cause_clr, .irq_en, .cause, .irq);
endmodule

// File: tb/cdl_engine_tb_top.sv
`timescale 1ns/1ps
module cdl_engine_tb_top;
  import cdl_pkg::*;

  localparam logic [63:0] IN_BASE  = 64'h0000_0001_0000_2000;
  localparam logic [63:0] OUT_BASE = 64'h0000_0002_0000_8000;
  localparam logic [63:0] SHD_BASE = 64'h0000_0002_0000_F000;
  // {flag offered, unit value expected in host memory}
  localparam logic [63:0] CPL_VEC [4] = '{
    {32'h0000_0001, 32'h8000_0001},
    {32'h0000_00A5, 32'h8000_00A5},
    {32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0010, 32'h8000_0010}};

  logic        clk, rst_n, reg_wr, req_valid, req_ready, cpl_valid, cpl_ready;
  logic        hwr_en, msg_cmd_new, msg_rsp_wr, irq;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, req_size, cpl_flag, hwr_data, msg_cmd, msg_rsp_data;
  logic [63:0] inb_rd_addr, req_addr, hwr_addr;
  logic [95:0] inb_rd_data;
  logic [95:0] inb_mem [256];
  logic [31:0] rd;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  assign inb_rd_data = inb_mem[8'((inb_rd_addr - IN_BASE) >> 4)];

  cdl_engine dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [63:0] buf_of(int k);
    return 64'h0000_0040_2000_0000 + 64'(k) * 64'h100;
  endfunction

  task automatic take_unit(int k, string req);
    @(negedge clk); req_ready = 1'b1; #1;
    chk({req, " valid"}, req_valid, 1);
    chk({req, " fetch addr"}, inb_rd_addr, IN_BASE + 64'(k) * 16);
    chk({req, " buf addr"}, req_addr, buf_of(k));
    chk({req, " size"}, req_size, 64'(32'h40 + k));
  endtask

  task automatic post_one(logic [31:0] flag, logic [31:0] exp_unit, int idx, string req);
    @(negedge clk); cpl_valid = 1'b1; cpl_flag = flag; #1;
    chk({req, " ready"}, cpl_ready, 1);
    chk({req, " unit addr"}, hwr_addr, OUT_BASE + 64'(idx) * 4);
    chk({req, " unit data"}, {hwr_en, hwr_data}, {1'b1, exp_unit});
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk({req, " shadow cycle ready low"}, cpl_ready, 0);
    chk({req, " shadow write"}, {hwr_en, hwr_addr, hwr_data}, {1'b1, SHD_BASE, 32'(idx)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; req_ready = 1'b0;
    cpl_valid = 1'b0; cpl_flag = '0; msg_rsp_wr = 1'b0; msg_rsp_data = '0;
    for (int k = 0; k < 256; k++) inb_mem[k] = {32'h40 + 32'(k), buf_of(k) + 64'd5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 req_valid", req_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cpl_ready", cpl_ready, 1);
    reg_read(A_WPTR, rd);   chk("R1 write index", rd, 7);
    reg_read(A_SHADOW, rd); chk("R1 shadow", rd, 7);
    reg_read(A_HRIDX, rd);  chk("R1 host read index", rd, 7);

    // R9 base setup and readback
    reg_write(A_IN_LO, IN_BASE[31:0]);   reg_write(A_IN_HI, IN_BASE[63:32]);
    reg_write(A_OUT_LO, OUT_BASE[31:0]); reg_write(A_OUT_HI, OUT_BASE[63:32]);
    reg_write(A_SHD_LO, SHD_BASE[31:0]); reg_write(A_SHD_HI, SHD_BASE[63:32]);
    reg_write(A_ENABLE, 32'h3);
    reg_read(A_IN_HI, rd);  chk("R9 request base high", rd, 64'(IN_BASE[63:32]));
    reg_read(A_OUT_LO, rd); chk("R9 completion base low", rd, 64'(OUT_BASE[31:0]));
    reg_read(A_SHD_LO, rd); chk("R9 shadow address low", rd, 64'(SHD_BASE[31:0]));

    // R2 three units posted, stalled then drained
    reg_write(A_WPTR, 32'd2);
    #1 chk("R2 stalled valid", req_valid, 1);
    for (int k = 0; k < 3; k++) take_unit(k, "R2");
    @(negedge clk); req_ready = 1'b0; #1;
    chk("R2 drained", req_valid, 0);

    // R3 wrap through the end of the ring
    reg_write(A_WPTR, 32'd1);
    for (int k = 3; k < 10; k++) take_unit(k % 8, "R3");
    @(negedge clk); req_ready = 1'b0; #1;
    chk("R3 drained after wrap", req_valid, 0);
    reg_write(A_WPTR, 32'd9);
    reg_read(A_WPTR, rd); chk("R3 write index reduced", rd, 1);
    chk("R3 no spurious unit", req_valid, 0);

    // R4 completion vectors
    for (int i = 0; i < 4; i++) post_one(CPL_VEC[i][63:32], CPL_VEC[i][31:0], i, "R4");
    reg_read(A_SHADOW, rd); chk("R4 shadow register", rd, 3);
    chk("R7 irq after completions", irq, 1);
    reg_read(A_CAUSE, rd); chk("R7 cause", rd, 1);
    reg_write(A_CAUSE, 32'h1);
    #1 chk("R7 cleared", irq, 0);

    // R5 fill to N-1 units, then hold one against a full ring
    reg_write(A_ENABLE, 32'h2);
    for (int i = 4; i < 7; i++) post_one(32'h100 + 32'(i), 32'h8000_0100 + 32'(i), i, "R5");
    @(negedge clk); cpl_valid = 1'b1; cpl_flag = 32'h1234; #1;
    chk("R5 full ready", cpl_ready, 0);
    chk("R5 full no write", hwr_en, 0);
    @(negedge clk); #1;
    chk("R5 still held", {cpl_ready, hwr_en}, 0);
    reg_write(A_HRIDX, 32'd0);
    #1 chk("R5 released", cpl_ready, 1);
    chk("R5 last unit", {hwr_addr, hwr_data}, {OUT_BASE + 64'd28, 32'h8000_1234});
    @(negedge clk); cpl_valid = 1'b0; #1;
    chk("R4 wrap shadow write", {hwr_en, hwr_data}, {1'b1, 32'd7});
    chk("R7 masked cause", irq, 0);
    reg_read(A_CAUSE, rd); chk("R7 cause held while masked", rd, 1);
    reg_write(A_ENABLE, 32'h3);
    #1 chk("R7 enable raises irq", irq, 1);
    reg_write(A_CAUSE, 32'h1);

    // R8 message pair
    reg_write(A_MSG_CMD, 32'h55);
    #1 chk("R8 command pulse", {msg_cmd_new, msg_cmd}, {1'b1, 32'h55});
    @(negedge clk); #1 chk("R8 pulse one cycle", msg_cmd_new, 0);
    reg_read(A_MSG_DONE, rd); chk("R8 not done", rd, 0);
    @(negedge clk); msg_rsp_wr = 1'b1; msg_rsp_data = 32'h55;
    @(negedge clk); msg_rsp_wr = 1'b0;
    reg_read(A_MSG_DONE, rd); chk("R8 done", rd, 1);
    reg_read(A_MSG_RSP, rd);  chk("R8 response", rd, 32'h55);
    chk("R7 message irq", irq, 1);
    reg_read(A_CAUSE, rd);    chk("R7 message cause", rd, 2);
    reg_write(A_CAUSE, 32'h2);
    #1 chk("R7 message cleared", irq, 0);

    // R6 ring size change
    reg_write(A_CFG, 32'd2);
    reg_read(A_WPTR, rd);   chk("R6 write index", rd, 3);
    reg_read(A_SHADOW, rd); chk("R6 producer index", rd, 3);
    reg_read(A_HRIDX, rd);  chk("R6 host read index", rd, 3);
    chk("R6 no unit", req_valid, 0);
    chk("R6 completions open", cpl_ready, 1);
    reg_write(A_CFG, 32'd0);  reg_read(A_CFG, rd); chk("R6 clamp low", rd, 1);
    reg_write(A_CFG, 32'd15); reg_read(A_CFG, rd); chk("R6 clamp high", rd, 8);
    reg_write(A_CFG, 32'd2);
    reg_write(A_WPTR, 32'd1);
    for (int k = 0; k < 2; k++) take_unit(k, "R6");
    @(negedge clk); req_ready = 1'b0;
    reg_write(A_WPTR, 32'd6);
    reg_read(A_WPTR, rd); chk("R3 reduced in small ring", rd, 2);
    chk("R3 small ring fetch", {req_valid, inb_rd_addr}, {1'b1, IN_BASE + 64'd32});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule